// File: doc/BRIEF.md
# Operate Execution Unit with Condition Codes

This block is the integer execute stage for the three register-to-register operate instructions of a small 16-bit machine: addition, bitwise AND and bitwise complement. It owns eight 16-bit general-purpose registers and a three-flag condition code (negative, zero, positive). When the execute strobe is high at a rising clock edge, the block decodes the presented instruction word. It reads one or two source registers, or one source register and a sign-extended 5-bit immediate, and writes the result to the destination register at that same edge. The flags update from the result at the same edge.

Instruction fetch, memory access, branches and traps happen elsewhere. A debug port lets the surrounding logic or a test read any register, and the flags are always visible.

Top module: `op_exec_unit`

## Requirements
- R1: While rst_ni is low, all eight registers clear to zero and flags_o reads 3'b010 (zero). flags_o bit 2 is negative, bit 1 is zero and bit 0 is positive.
- R2: Opcode 4'b0001 in bits 15:12 with bit 5 = 0 writes the 16-bit sum, modulo 2^16, of the register selected by bits 8:6 and the register selected by bits 2:0. The destination is the register selected by bits 11:9. No other register changes.
- R3: Opcode 4'b0001 with bit 5 = 1 adds bits 4:0, sign-extended to 16 bits (range -16 to +15), to the register selected by bits 8:6.
- R4: Opcode 4'b0101 performs a bitwise AND. It uses the same operand selection as R2 and R3: bit 5 = 0 takes the register in bits 2:0, and bit 5 = 1 takes the sign-extended bits 4:0.
- R5: Opcode 4'b1001 writes the bitwise complement of the register selected by bits 8:6. Bits 5:0 of the instruction have no effect.
- R6: After every register write, exactly one flag is set: negative if result bit 15 is 1, zero if the result is 0, and positive otherwise.
- R7: With exec_i low, or with exec_i high and any opcode other than the three above, no register and no flag changes.
- R8: A source register may also be the destination. The operation uses the value held before the edge, and the result is visible after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe, sampled at the rising edge |
| instr_i | input | 16 | Instruction word |
| dbg_sel_i | input | 3 | Register index for the debug read |
| dbg_data_o | output | 16 | Contents of the register selected by dbg_sel_i |
| flags_o | output | 3 | Condition code {negative, zero, positive} |

## Verification
The bench probes the edges of the immediate field. It uses +15, -16 and -1, so a design that zero-extends the field, or truncates it wrongly, writes a result that is off by a power of two. It adds a negative value to reach exactly zero, so a design that takes the zero flag from the carry or the sign bit shows the wrong flags. It runs an addition whose source and destination are the same register, which exposes a design that reads the value just written. It also issues a complement with its low bits set and then clear, a non-operate opcode aimed at a live register, and a valid word with the strobe low. A design that leaks any of these into state shows a changed register or changed flags.

// File: rtl/op_exec_pkg.sv
package op_exec_pkg;
  localparam int INSTR_W   = 16;
  localparam int SEL_W     = 3;
  localparam int IMM_W     = 5;
  localparam int OPC_LO    = 12;
  localparam int DST_LO    = 9;
  localparam int SRC1_LO   = 6;
  localparam int MODE_BIT  = 5;
  localparam int SRC2_LO   = 0;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_INV = 4'b1001;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_AND = 2'd1,
    ALU_INV = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;

  localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};
endpackage

// File: rtl/op_exec_decode.sv
module op_exec_decode
  import op_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               exec_i,
  output logic               wr_en_o,
  output alu_op_e            alu_op_o,
  output logic [SEL_W-1:0]   dst_o,
  output logic [SEL_W-1:0]   src1_o,
  output logic [SEL_W-1:0]   src2_o,
  output logic               use_imm_o,
  output logic [DATA_W-1:0]  imm_o
);
  logic [3:0] opc;
  logic       known;

  assign opc    = instr_i[INSTR_W-1:OPC_LO];
  assign dst_o  = instr_i[DST_LO+:SEL_W];
  assign src1_o = instr_i[SRC1_LO+:SEL_W];
  assign src2_o = instr_i[SRC2_LO+:SEL_W];
  assign imm_o  = {{(DATA_W-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};

  always_comb begin
    known     = 1'b1;
    alu_op_o  = ALU_ADD;
    use_imm_o = instr_i[MODE_BIT];
    case (opc)
      OPC_ADD: alu_op_o = ALU_ADD;
      OPC_AND: alu_op_o = ALU_AND;
      OPC_INV: begin
        alu_op_o  = ALU_INV;
        use_imm_o = 1'b0;  // low bits are don't-care for complement
      end
      default: known = 1'b0;
    endcase
  end

  assign wr_en_o = exec_i & known;
endmodule

// File: rtl/op_exec_regfile.sv
module op_exec_regfile #(
  parameter int DATA_W   = 16,
  parameter int SEL_W    = 3,
  parameter int NUM_REGS = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_a_addr_i,
  input  logic [SEL_W-1:0]  rd_b_addr_i,
  input  logic [SEL_W-1:0]  rd_d_addr_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  output logic [DATA_W-1:0] rd_d_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              we;
    assign we = wr_en_i && (wr_addr_i == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (we)  q <= wr_data_i;
    end
    assign regs[g] = q;
  end

  // reads see pre-edge contents; write lands at the edge
  assign rd_a_o = regs[rd_a_addr_i];
  assign rd_b_o = regs[rd_b_addr_i];
  assign rd_d_o = regs[rd_d_addr_i];
endmodule

// File: rtl/op_exec_alu.sv
module op_exec_alu
  import op_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output cc_t               cc_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_INV: res_o = ~a_i;
      default: res_o = a_i;
    endcase
  end

  assign cc_o.n = res_o[DATA_W-1];
  assign cc_o.z = (res_o == '0);
  assign cc_o.p = ~res_o[DATA_W-1] & (res_o != '0);
endmodule

// File: rtl/op_exec_unit.sv
module op_exec_unit
  import op_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [SEL_W-1:0]   dbg_sel_i,
  output logic [DATA_W-1:0]  dbg_data_o,
  output logic [2:0]         flags_o
);
  logic              wr_en;
  logic [SEL_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;
  alu_op_e           alu_op;
  logic [SEL_W-1:0]  src1, src2;
  logic              use_imm;
  logic [DATA_W-1:0] imm;
  logic [DATA_W-1:0] opnd_a, reg_b, opnd_b;
  cc_t               cc_next, cc_q;

  op_exec_decode #(.DATA_W(DATA_W)) u_dec (
    .instr_i   (instr_i),
    .exec_i    (exec_i),
    .wr_en_o   (wr_en),
    .alu_op_o  (alu_op),
    .dst_o     (wr_addr),
    .src1_o    (src1),
    .src2_o    (src2),
    .use_imm_o (use_imm),
    .imm_o     (imm)
  );

  op_exec_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_a_addr_i (src1),
    .rd_b_addr_i (src2),
    .rd_d_addr_i (dbg_sel_i),
    .rd_a_o      (opnd_a),
    .rd_b_o      (reg_b),
    .rd_d_o      (dbg_data_o)
  );

  assign opnd_b = use_imm ? imm : reg_b;

  op_exec_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .op_i  (alu_op),
    .res_o (wr_data),
    .cc_o  (cc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cc_q <= CC_RESET;
    else if (wr_en) cc_q <= cc_next;
  end

  assign flags_o = {cc_q.n, cc_q.z, cc_q.p};
endmodule

// File: rtl/op_exec_unit_chk.sv
module op_exec_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [15:0]       instr_i,
  input logic [2:0]        flags_o,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  logic opc_known;
  assign opc_known = (instr_i[15:12] == 4'b0001) || (instr_i[15:12] == 4'b0101) ||
                     (instr_i[15:12] == 4'b1001);

  assert_cc_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flags_o) == 1);

  assert_cc_follows_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (flags_o[2] == $past(wr_data[DATA_W-1])) &&
              (flags_o[1] == ($past(wr_data) == '0)));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(flags_o));

  assert_bad_opcode_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !opc_known) |-> !wr_en);

  assert_write_needs_exec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> exec_i);

  assert_dst_field_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_addr == instr_i[11:9]));
endmodule

bind op_exec_unit op_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .exec_i  (exec_i),
  .instr_i (instr_i),
  .flags_o (flags_o),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data)
);

// File: tb/tb_op_exec_unit.sv
`timescale 1ns/1ps
module tb_op_exec_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exec_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [2:0]  dbg_sel_i = '0;
  logic [15:0] dbg_data_o;
  logic [2:0]  flags_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  op_exec_unit dut (.*);

  typedef struct packed {
    logic [15:0] ins;
    logic [2:0]  dst;
    logic [15:0] val;
    logic [2:0]  cc;   // {N,Z,P}
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{16'h1225, 3'd1, 16'h0005, 3'b001, "R3"},  // R1 = R0 + 5
    '{16'h147D, 3'd2, 16'h0002, 3'b001, "R3"},  // R2 = R1 + (-3)
    '{16'h1642, 3'd3, 16'h0007, 3'b001, "R2"},  // R3 = R1 + R2
    '{16'h98FF, 3'd4, 16'hFFF8, 3'b100, "R5"},  // R4 = ~R3, low bits all set
    '{16'h5B03, 3'd5, 16'h0000, 3'b010, "R4"},  // R5 = R4 & R3
    '{16'h5D3F, 3'd6, 16'hFFF8, 3'b100, "R4"},  // R6 = R4 & -1
    '{16'h1241, 3'd1, 16'h000A, 3'b001, "R8"},  // R1 = R1 + R1
    '{16'h1F28, 3'd7, 16'h0000, 3'b010, "R2"},  // R7 = R4 + 8, wraps to zero
    '{16'h1FAF, 3'd7, 16'h0007, 3'b001, "R3"},  // R7 = R6 + 15
    '{16'h11B0, 3'd0, 16'hFFE8, 3'b100, "R3"},  // R0 = R6 + (-16)
    '{16'h9480, 3'd2, 16'hFFFD, 3'b100, "R5"}   // R2 = ~R2, low bits clear
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] ins, input logic en);
    @(negedge clk_i);
    instr_i = ins;
    exec_i  = en;
    @(negedge clk_i);
    exec_i  = 1'b0;
  endtask

  task automatic peek(input logic [2:0] idx, output logic [15:0] v);
    dbg_sel_i = idx;
    #0.5;
    v = dbg_data_o;
  endtask

  initial begin
    logic [15:0] v;
    #12;
    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      peek(3'(i), v);
      check("R1 reg in reset", v, 16'h0000);
    end
    check("R1 flags in reset", {13'd0, flags_o}, 16'h0002);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      run(VEC[k].ins, 1'b1);
      peek(VEC[k].dst, v);
      check($sformatf("%s vec%0d value", VEC[k].tag, k), v, VEC[k].val);
      check($sformatf("R6 vec%0d flags", k), {13'd0, flags_o}, {13'd0, VEC[k].cc});
    end

    // R2: other registers untouched by the run
    peek(3'd3, v); check("R2 R3 unchanged", v, 16'h0007);
    peek(3'd4, v); check("R2 R4 unchanged", v, 16'hFFF8);

    // R7: unknown opcode aimed at R7 with execute high
    run(16'h3E3F, 1'b1);
    peek(3'd7, v); check("R7 bad opcode reg", v, 16'h0007);
    check("R7 bad opcode flags", {13'd0, flags_o}, 16'h0004);

    // R7: valid ADD R7,R0,#-1 with execute low
    run(16'h1E3F, 1'b0);
    peek(3'd7, v); check("R7 exec low reg", v, 16'h0007);
    check("R7 exec low flags", {13'd0, flags_o}, 16'h0004);

    // R8: AND R3,R3,#1 -> 7 & 1 = 1
    run(16'h56E1, 1'b1);
    peek(3'd3, v); check("R8 self AND", v, 16'h0001);
    check("R6 self AND flags", {13'd0, flags_o}, 16'h0001);

    // R1: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    peek(3'd0, v); check("R1 re-reset R0", v, 16'h0000);
    peek(3'd7, v); check("R1 re-reset R7", v, 16'h0000);
    check("R1 re-reset flags", {13'd0, flags_o}, 16'h0002);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule